// File: doc/BRIEF.md
# PTP One-Step Timestamp Inserter

This block sits inline on a 16-bit transmit packet stream, two bytes per beat. The stream uses valid/ready handshaking and carries start-of-frame and end-of-frame markers. On the start beat of every frame it reads a two-bit operation code and a 16-bit byte offset. The offset is measured from the first destination-address byte, which is offset 0.

For one-step frames it takes the free-running 80-bit system time at the edge where the start beat is accepted. That time holds 48 bits of seconds above 32 bits of nanoseconds. The block writes it over the frame payload in place, most significant byte first, across five consecutive beats starting at the beat that holds the offset. Every other frame, and every beat outside the field, passes through untouched.

The datapath is combinational from input to output and only frame context is registered, so the block adds no latency and no backpressure. A frame that ends before the whole field has been written loses the unwritten bytes and sets a sticky flag.

Top module: `ptp_onestep_inserter`

## Requirements
- R1: `m_valid_o`, `m_sop_o` and `m_eop_o` equal `s_valid_i`, `s_sop_i` and `s_eop_i` in the same cycle. `s_ready_o` equals `m_ready_i`. A beat transfers when valid and ready are both high.
- R2: A frame whose start beat carries operation code 2'b00 leaves the block with every beat's data unchanged.
- R3: Codes 2'b10 and 2'b11 also leave all data unchanged.
- R4: The operation code and offset are taken only from the start beat. Their values on later beats of the same frame have no effect on the output data.
- R5: With code 2'b01 the beats are numbered k = 0, 1, 2, ... from the start beat. Beat k holds byte 2k in bits [15:8] and byte 2k+1 in bits [7:0]. For s = offset/2, beat s+j (j = 0..4) carries timestamp bits [79-16j -: 16], and all other beats are unchanged.
- R6: The timestamp written is `time_i` in the cycle the start beat transfers. Time changes in cycles where the start beat is stalled, or in later cycles, do not alter it. Stalled cycles and bubbles do not advance the beat count.
- R7: With offset 0, the start beat itself carries timestamp bits [79:64].
- R8: Bit 0 of the offset is ignored, so odd offset 2s+1 behaves as 2s.
- R9: `trunc_o` rises in the cycle after a one-step frame's end beat transfers with beat index below s+4. It then stays high until reset. Frames that reach beat s+4 or beyond do not set it.
- R10: After reset `trunc_o` is 0 and no frame context is held, so beats arriving before any start beat pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 80 | Free-running system time, seconds[79:32] and nanoseconds[31:0] |
| s_valid_i | input | 1 | Upstream beat valid |
| s_ready_o | output | 1 | Upstream ready |
| s_data_i | input | 16 | Upstream beat data |
| s_sop_i | input | 1 | Upstream start-of-frame marker |
| s_eop_i | input | 1 | Upstream end-of-frame marker |
| s_op_i | input | 2 | Per-frame operation code, read on the start beat |
| s_offset_i | input | 16 | Per-frame field byte offset, read on the start beat |
| m_valid_o | output | 1 | Downstream beat valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | 16 | Downstream beat data |
| m_sop_o | output | 1 | Downstream start-of-frame marker |
| m_eop_o | output | 1 | Downstream end-of-frame marker |
| trunc_o | output | 1 | Sticky flag: a one-step field was cut short by end of frame |

## Verification
Several properties are checked on every cycle. Non-one-step beats must leave the data untouched. An offset-0 start beat must carry the top time word. The context must clear after each end beat and the beat counter must restart after each start beat. The truncation flag must be sticky and may rise only after an end beat. What the assertions cannot show is the exact placement and byte order of the five-word field, which timestamp value wins when the start beat stalls while time keeps moving, and whether mid-frame changes of code and offset are ignored. The scenario table covers those by replaying whole frames and comparing every output beat against values computed from the requirements.

// File: rtl/ptp_ins_pkg.sv
package ptp_ins_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ONE  = 2'b01,
    OP_TWO  = 2'b10,
    OP_RSV  = 2'b11
  } ptp_op_e;
endpackage

// File: rtl/ptp_ins_ctx.sv
module ptp_ins_ctx
  import ptp_ins_pkg::*;
#(
  parameter int TS_W  = 80,
  parameter int IDX_W = 15,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] start_i,
  input  logic [TS_W-1:0]  time_i,
  output ptp_op_e          op_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [IDX_W-1:0] start_o,
  output logic [TS_W-1:0]  ts_o
);
  ptp_op_e          op_q;
  logic [CNT_W-1:0] idx_q;
  logic [IDX_W-1:0] start_q;
  logic [TS_W-1:0]  ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_NONE;
      idx_q   <= '0;
      start_q <= '0;
      ts_q    <= '0;
    end else if (fire_i) begin
      if (sop_i) begin
        op_q    <= eop_i ? OP_NONE : ptp_op_e'(op_i);
        idx_q   <= CNT_W'(1);
        start_q <= start_i;
        ts_q    <= time_i;
      end else begin
        if (eop_i) op_q <= OP_NONE;
        if (idx_q != '1) idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  // the start beat sees live inputs; later beats see latched context
  assign op_o    = sop_i ? ptp_op_e'(op_i) : op_q;
  assign idx_o   = sop_i ? '0 : idx_q;
  assign start_o = sop_i ? start_i : start_q;
  assign ts_o    = sop_i ? time_i : ts_q;

  assert_ctx_clear_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && eop_i) |=> (op_q == OP_NONE));

  assert_idx_restart_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && sop_i && !eop_i) |=> (idx_q == CNT_W'(1)));

  assert_ts_hold_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && sop_i) |=> $stable(ts_q));
endmodule

// File: rtl/ptp_ins_sel.sv
module ptp_ins_sel
  import ptp_ins_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 80,
  parameter int IDX_W  = 15,
  localparam int CNT_W = IDX_W + 1,
  localparam int WORDS = TS_W / DATA_W,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  ptp_op_e           op_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  start_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              pending_o
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = ts_i[TS_W-1-g*DATA_W -: DATA_W];
  end

  logic [CNT_W:0] idx_x, st_x, rel;
  logic           one, in_field;

  assign idx_x    = {1'b0, idx_i};
  assign st_x     = {2'b00, start_i};
  assign rel      = idx_x - st_x;
  assign one      = (op_i == OP_ONE);
  assign in_field = one && (idx_x >= st_x) && (rel < (CNT_W+1)'(WORDS));

  assign dout_o    = in_field ? words[rel[SEL_W-1:0]] : din_i;
  assign pending_o = one && (idx_x < st_x + (CNT_W+1)'(WORDS - 1));
endmodule

// File: rtl/ptp_onestep_inserter.sv
module ptp_onestep_inserter
  import ptp_ins_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 80,
  parameter int OFF_W  = 16,
  localparam int BYTES = DATA_W / 8,
  localparam int SHIFT = $clog2(BYTES),
  localparam int IDX_W = OFF_W - SHIFT,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   time_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_sop_i,
  input  logic              s_eop_i,
  input  logic [1:0]        s_op_i,
  input  logic [OFF_W-1:0]  s_offset_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_sop_o,
  output logic              m_eop_o,
  output logic              trunc_o
);
  logic fire;
  assign fire      = s_valid_i & m_ready_i;
  assign s_ready_o = m_ready_i;
  assign m_valid_o = s_valid_i;
  assign m_sop_o   = s_sop_i;
  assign m_eop_o   = s_eop_i;

  // sub-beat offset bits do not select anything
  logic unused_off_lsb;
  assign unused_off_lsb = ^s_offset_i[SHIFT-1:0];

  ptp_op_e          cur_op;
  logic [CNT_W-1:0] cur_idx;
  logic [IDX_W-1:0] cur_start;
  logic [TS_W-1:0]  cur_ts;
  logic             pending;

  ptp_ins_ctx #(.TS_W(TS_W), .IDX_W(IDX_W)) u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .sop_i   (s_sop_i),
    .eop_i   (s_eop_i),
    .op_i    (s_op_i),
    .start_i (s_offset_i[OFF_W-1:SHIFT]),
    .time_i  (time_i),
    .op_o    (cur_op),
    .idx_o   (cur_idx),
    .start_o (cur_start),
    .ts_o    (cur_ts)
  );

  ptp_ins_sel #(.DATA_W(DATA_W), .TS_W(TS_W), .IDX_W(IDX_W)) u_sel (
    .op_i      (cur_op),
    .idx_i     (cur_idx),
    .start_i   (cur_start),
    .ts_i      (cur_ts),
    .din_i     (s_data_i),
    .dout_o    (m_data_o),
    .pending_o (pending)
  );

  logic trunc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        trunc_q <= 1'b0;
    else if (fire && s_eop_i && pending) trunc_q <= 1'b1;
  end
  assign trunc_o = trunc_q;

  assert_untouched_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && cur_op != OP_ONE) |-> (m_data_o == s_data_i));

  assert_sop_field_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_sop_i && s_op_i == OP_ONE && s_offset_i[OFF_W-1:SHIFT] == '0)
      |-> (m_data_o == time_i[TS_W-1 -: DATA_W]));

  assert_trunc_sticky_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |=> trunc_o);

  assert_trunc_cause_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trunc_o) |-> $past(fire && s_eop_i));
endmodule

// File: tb/sim_ptp_onestep_inserter.sv
module sim_ptp_onestep_inserter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] tm = 80'h0000_1234_5678_9abc_def0;
  logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, m_ready = 1'b1;
  logic [15:0] s_data = '0, s_off = '0;
  logic [1:0]  s_op = '0;
  logic        s_ready, m_valid, m_sop, m_eop, trunc;
  logic [15:0] m_data;

  always #2 clk = ~clk;

  ptp_onestep_inserter u0 (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .s_sop_i(s_sop), .s_eop_i(s_eop), .s_op_i(s_op), .s_offset_i(s_off),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .m_sop_o(m_sop), .m_eop_o(m_eop), .trunc_o(trunc)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [15:0] exp_word(logic [1:0] op, logic [15:0] off, int k,
                                           logic [79:0] ts, logic [15:0] din);
    int st;
    st = int'(off >> 1);
    if (op == 2'b01 && k >= st && k < st + 5) return ts[79 - 16*(k - st) -: 16];
    return din;
  endfunction

  // plays one frame; compares every output beat in every cycle
  task automatic run_frame(int f, logic [1:0] op, logic [15:0] off, int len,
                           int stall, bit bubble, string req);
    logic [79:0] ts_cap;
    logic [79:0] bad_act, bad_exp;
    bit ok;
    ok = 1'b1; ts_cap = '0; bad_act = '0; bad_exp = '0;
    for (int k = 0; k < len; k++) begin
      int waits;
      waits = (k == stall) ? 2 : 0;
      for (int w = 0; w <= waits; w++) begin
        logic [15:0] e;
        @(negedge clk);
        tm = tm + 80'd1237;
        s_valid = 1'b1;
        s_data  = 16'(f * 256 + k);
        s_sop   = (k == 0);
        s_eop   = (k == len - 1);
        s_op    = (k == 0) ? op : (op ^ 2'b01);   // R4: mid-frame garbage
        s_off   = (k == 0) ? off : 16'd0;
        m_ready = (w == waits);
        #1;
        e = exp_word(op, off, k, (k == 0) ? tm : ts_cap, s_data);
        if (ok && (m_data !== e || m_valid !== 1'b1 || s_ready !== m_ready ||
                   m_sop !== s_sop || m_eop !== s_eop)) begin
          ok = 1'b0;
          bad_act = {59'd0, m_valid, s_ready, m_sop, m_eop, m_data, 1'b0};
          bad_exp = {59'd0, 1'b1, m_ready, s_sop, s_eop, e, 1'b0};
        end
      end
      if (k == 0) ts_cap = tm;
      if (bubble && k != len - 1) begin
        @(negedge clk);
        tm = tm + 80'd1237;
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
        #1;
        if (ok && m_valid !== 1'b0) begin
          ok = 1'b0; bad_act = {79'd0, m_valid}; bad_exp = '0;
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; m_ready = 1'b1;
    check(ok, req, bad_act, bad_exp);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] off;
    logic [7:0]  len;
    logic [7:0]  stall;   // 8'hFF = none
    logic        bubble;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{op: 2'b00, off: 16'd4, len: 8'd10, stall: 8'hFF, bubble: 1'b0},  // R2 R4
    '{op: 2'b01, off: 16'd4, len: 8'd10, stall: 8'hFF, bubble: 1'b0},  // R5 R4
    '{op: 2'b10, off: 16'd4, len: 8'd10, stall: 8'hFF, bubble: 1'b0},  // R3
    '{op: 2'b11, off: 16'd4, len: 8'd10, stall: 8'hFF, bubble: 1'b0},  // R3
    '{op: 2'b01, off: 16'd0, len: 8'd6,  stall: 8'hFF, bubble: 1'b0},  // R7
    '{op: 2'b01, off: 16'd8, len: 8'd9,  stall: 8'hFF, bubble: 1'b1},  // R5 R6 exact fit
    '{op: 2'b01, off: 16'd9, len: 8'd12, stall: 8'hFF, bubble: 1'b0},  // R8
    '{op: 2'b01, off: 16'd6, len: 8'd10, stall: 8'd0,  bubble: 1'b0},  // R6 stalled start
    '{op: 2'b01, off: 16'd2, len: 8'd10, stall: 8'd2,  bubble: 1'b1}   // R6 stall in field
  };
  localparam string TAGS [NV] = '{"R2 R4", "R5 R4", "R3", "R3", "R7", "R5 R6",
                                  "R8", "R6", "R6"};

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 80'd0, 80'd1);
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    check(trunc === 1'b0, "R10 reset flag", {79'd0, trunc}, 80'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: beat with no prior start beat passes unchanged even with one-step code
    @(negedge clk);
    s_valid = 1'b1; s_data = 16'hBEEF; s_op = 2'b01; s_off = 16'd0;
    #1;
    check(m_data === 16'hBEEF, "R10 no context", {64'd0, m_data}, {64'd0, 16'hBEEF});
    // R1: downstream stall seen upstream
    m_ready = 1'b0;
    #1;
    check(s_ready === 1'b0 && m_valid === 1'b1, "R1 ready passthrough",
          {78'd0, s_ready, m_valid}, {78'd0, 2'b01});
    @(negedge clk);
    s_valid = 1'b0; m_ready = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_frame(i + 1, VECS[i].op, VECS[i].off, int'(VECS[i].len),
                (VECS[i].stall == 8'hFF) ? -1 : int'(VECS[i].stall),
                VECS[i].bubble, TAGS[i]);
      check(trunc === 1'b0, "R9 no false flag", {79'd0, trunc}, 80'd0);
    end

    // R9: frame ends at beat 4, field spans beats 2..6
    run_frame(20, 2'b01, 16'd4, 5, -1, 1'b0, "R9 truncated data");
    #1;
    check(trunc === 1'b1, "R9 flag set", {79'd0, trunc}, 80'd1);
    run_frame(21, 2'b00, 16'd0, 4, -1, 1'b0, "R2");
    check(trunc === 1'b1, "R9 sticky", {79'd0, trunc}, 80'd1);

    // R9: one-step frame that ends before the field starts
    rst_n = 1'b0;
    #1;
    check(trunc === 1'b0, "R10 reset clears flag", {79'd0, trunc}, 80'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(22, 2'b01, 16'd20, 3, -1, 1'b0, "R9 short frame data");
    #1;
    check(trunc === 1'b1, "R9 flag before field", {79'd0, trunc}, 80'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule